// File: doc/BRIEF.md
# Monitor load detection sequencer

This block finds out whether an analog monitor is attached to a display DAC. It is a small master on a synchronous register bus. After a start pulse it runs one fixed sequence of register accesses against the DAC's output-control, test-control and test-data registers. It saves the live contents of output-control and test-control. It powers the DAC and briefly cuts the outputs, then re-enables the analog output. It drives test levels of about 30% of full scale onto the three colour lines and routes them to the outputs. It then samples the load comparator status bit, removes the test routing and writes both saved registers back. The sequence ends with a one-cycle done pulse that carries the detection result.

The two settling intervals are counted in clock cycles by a parameterised timer. The default of 100000 cycles gives 1 ms at 100 MHz. The `second_head` input selects how output-control is masked while the outputs are cut. When a second head exists, the head-assignment bit is cleared along with the output enables. On a single-head part that bit is left exactly as it was.

The sequencer is a single enumerated state machine with these states: IDLE, RD_OUT (save output-control), RD_TST (save test-control), WR_PWR (power up), WR_CUT (cut outputs), WAIT_CUT, RD_OUT2, WR_EN (re-enable analog output), WR_TDAT (load test levels), RD_TST2, WR_ROUTE (route test levels), WAIT_ROUTE, RD_SENSE (sample comparator), WR_UNROUTE, RST_OUT, RST_TST and DONE. The transitions are: IDLE to RD_OUT on start; every access state to its successor in that list in the cycle the bus reports ready; each wait state to its successor when the timer expires; DONE to IDLE unconditionally.

Top module: `monitor_probe_seq`

## Requirements
- R1: After reset the block is idle: `bus_req`, `done` and `present` are 0, and no access is made until `start` is seen.
- R2: A run begins with a read of output-control (address 0) and then a read of test-control (address 1). It ends with a write of the saved output-control value to address 0 and then a write of the saved test-control value to address 1. After the run both registers hold their values from before the run.
- R3: The third access writes test-control with the saved value and bit 16 cleared, which powers the DAC.
- R4: The fourth access writes output-control with the saved value ANDed with 0x0000FEEE when `second_head` is 1, or with 0x0000FFEE when it is 0.
- R5: After the cut write, no request is made for exactly WAIT_CYCLES cycles. Output-control is then read and written back with bit 0 set.
- R6: The next access writes 0x94050140 to test-data (address 2). This value has bits 31:30 = 2 and each 10-bit colour level set to 0x140.
- R7: Test-control is then read and written back with bit 12 set. After that write, no request is made for exactly WAIT_CYCLES cycles.
- R8: Test-control is then read, and its bit 28 becomes the detection result. Test-control is then written with that read value and bit 12 cleared.
- R9: Once raised, `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until the cycle in which `bus_ready` is 1. Read data is taken in that cycle.
- R10: `done` is high for exactly one cycle after the last restore write. `present` equals the detection result in that cycle and is 0 in all other cycles.
- R11: A `start` pulse that arrives while a run is in progress has no effect. The run completes normally and no further accesses follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a detection run when idle |
| second_head | input | 1 | A second display head exists (selects cut mask) |
| done | output | 1 | One-cycle pulse at the end of a run |
| present | output | 1 | Monitor detected; valid only while done is high |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid when bus_ready is high |
| bus_ready | input | 1 | Access completes in this cycle |

## Verification
A wrong state, or a wrong saved or captured value, shows up at the bus port on the very next access. It appears as a wrong address, direction or data word, or as an access out of order. A miscounted wait shows up as a gap of the wrong length before the access that follows it. A bad capture of the comparator bit appears only at the done pulse, and a corrupted saved value only in the last two writes. For that reason the bench also compares the restored register contents after every run.

// File: rtl/probe_pkg.sv
package probe_pkg;

    localparam int DATA_W = 32;

    localparam int OUT_EN_BIT  = 0;
    localparam int ROUTE_BIT   = 12;
    localparam int PWR_OFF_BIT = 16;
    localparam int SENSE_BIT   = 28;

    localparam logic [DATA_W-1:0] CUT_MASK_DUAL   = 32'h0000_FEEE;
    localparam logic [DATA_W-1:0] CUT_MASK_SINGLE = 32'h0000_FFEE;

    localparam logic [1:0] LEVEL_MODE = 2'b10;
    localparam logic [9:0] LEVEL_CODE = 10'h140;
    localparam logic [DATA_W-1:0] LEVEL_WORD = {LEVEL_MODE, LEVEL_CODE, LEVEL_CODE, LEVEL_CODE};

    typedef enum logic [4:0] {
        S_IDLE,
        S_RD_OUT,
        S_RD_TST,
        S_WR_PWR,
        S_WR_CUT,
        S_WAIT_CUT,
        S_RD_OUT2,
        S_WR_EN,
        S_WR_TDAT,
        S_RD_TST2,
        S_WR_ROUTE,
        S_WAIT_ROUTE,
        S_RD_SENSE,
        S_WR_UNROUTE,
        S_RST_OUT,
        S_RST_TST,
        S_DONE
    } probe_state_t;

endpackage

// File: rtl/probe_wait_timer.sv
module probe_wait_timer #(
    parameter int WAIT_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    // R5 / R7: the count never runs past the interval
    a_r5_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= LAST));

endmodule

// File: rtl/probe_access_decode.sv
module probe_access_decode
    import probe_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int OUT_ADDR  = 0,
    parameter int TST_ADDR  = 1,
    parameter int TDAT_ADDR = 2
) (
    input  probe_state_t      state,
    input  logic              second_head,
    input  logic [DATA_W-1:0] save_out,
    input  logic [DATA_W-1:0] save_tst,
    input  logic [DATA_W-1:0] cur,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OUT_ADDR);
    localparam logic [ADDR_W-1:0] A_TST  = ADDR_W'(TST_ADDR);
    localparam logic [ADDR_W-1:0] A_TDAT = ADDR_W'(TDAT_ADDR);

    logic [DATA_W-1:0] cut_mask;

    always_comb begin
        cut_mask = second_head ? CUT_MASK_DUAL : CUT_MASK_SINGLE;
        req   = 1'b1;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        unique case (state)
            S_RD_OUT: begin
                addr = A_OUT;
            end
            S_RD_TST: begin
                addr = A_TST;
            end
            S_WR_PWR: begin
                we    = 1'b1;
                addr  = A_TST;
                wdata = save_tst & ~(DATA_W'(1) << PWR_OFF_BIT);
            end
            S_WR_CUT: begin
                we    = 1'b1;
                addr  = A_OUT;
                wdata = save_out & cut_mask;
            end
            S_RD_OUT2: begin
                addr = A_OUT;
            end
            S_WR_EN: begin
                we    = 1'b1;
                addr  = A_OUT;
                wdata = cur | (DATA_W'(1) << OUT_EN_BIT);
            end
            S_WR_TDAT: begin
                we    = 1'b1;
                addr  = A_TDAT;
                wdata = LEVEL_WORD;
            end
            S_RD_TST2: begin
                addr = A_TST;
            end
            S_WR_ROUTE: begin
                we    = 1'b1;
                addr  = A_TST;
                wdata = cur | (DATA_W'(1) << ROUTE_BIT);
            end
            S_RD_SENSE: begin
                addr = A_TST;
            end
            S_WR_UNROUTE: begin
                we    = 1'b1;
                addr  = A_TST;
                wdata = cur & ~(DATA_W'(1) << ROUTE_BIT);
            end
            S_RST_OUT: begin
                we    = 1'b1;
                addr  = A_OUT;
                wdata = save_out;
            end
            S_RST_TST: begin
                we    = 1'b1;
                addr  = A_TST;
                wdata = save_tst;
            end
            default: begin
                req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/monitor_probe_seq.sv
module monitor_probe_seq
    import probe_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int WAIT_CYCLES = 100000,
    parameter int OUT_ADDR    = 0,
    parameter int TST_ADDR    = 1,
    parameter int TDAT_ADDR   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              second_head,
    output logic              done,
    output logic              present,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ready
);
    probe_state_t      state, state_nx;
    logic [DATA_W-1:0] save_out, save_tst, cur;
    logic              sense_q;
    logic              wait_run, wait_expired;
    logic              step;

    probe_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .expired (wait_expired)
    );

    probe_access_decode #(
        .ADDR_W    (ADDR_W),
        .OUT_ADDR  (OUT_ADDR),
        .TST_ADDR  (TST_ADDR),
        .TDAT_ADDR (TDAT_ADDR)
    ) u_decode (
        .state       (state),
        .second_head (second_head),
        .save_out    (save_out),
        .save_tst    (save_tst),
        .cur         (cur),
        .req         (bus_req),
        .we          (bus_we),
        .addr        (bus_addr),
        .wdata       (bus_wdata)
    );

    assign wait_run = (state == S_WAIT_CUT) || (state == S_WAIT_ROUTE);
    assign step     = bus_req && bus_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:       if (start)        state_nx = S_RD_OUT;
            S_RD_OUT:     if (step)         state_nx = S_RD_TST;
            S_RD_TST:     if (step)         state_nx = S_WR_PWR;
            S_WR_PWR:     if (step)         state_nx = S_WR_CUT;
            S_WR_CUT:     if (step)         state_nx = S_WAIT_CUT;
            S_WAIT_CUT:   if (wait_expired) state_nx = S_RD_OUT2;
            S_RD_OUT2:    if (step)         state_nx = S_WR_EN;
            S_WR_EN:      if (step)         state_nx = S_WR_TDAT;
            S_WR_TDAT:    if (step)         state_nx = S_RD_TST2;
            S_RD_TST2:    if (step)         state_nx = S_WR_ROUTE;
            S_WR_ROUTE:   if (step)         state_nx = S_WAIT_ROUTE;
            S_WAIT_ROUTE: if (wait_expired) state_nx = S_RD_SENSE;
            S_RD_SENSE:   if (step)         state_nx = S_WR_UNROUTE;
            S_WR_UNROUTE: if (step)         state_nx = S_RST_OUT;
            S_RST_OUT:    if (step)         state_nx = S_RST_TST;
            S_RST_TST:    if (step)         state_nx = S_DONE;
            S_DONE:                         state_nx = S_IDLE;
            default:                        state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_out <= '0;
            save_tst <= '0;
            cur      <= '0;
            sense_q  <= 1'b0;
        end else if (step) begin
            unique case (state)
                S_RD_OUT:  save_out <= bus_rdata;
                S_RD_TST:  save_tst <= bus_rdata;
                S_RD_OUT2: cur      <= bus_rdata;
                S_RD_TST2: cur      <= bus_rdata;
                S_RD_SENSE: begin
                    cur     <= bus_rdata;
                    sense_q <= bus_rdata[SENSE_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        done    = (state == S_DONE);
        present = done && sense_q;
    end

    // R9: a pending request holds its command until accepted
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R10: done lasts a single cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: no bus traffic alongside the done pulse
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    // R11: a running sequence never falls back to idle before done
    a_r11_busy_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_DONE) |=> (state != S_IDLE));

endmodule

// File: tb/monitor_probe_seq_test.sv
module monitor_probe_seq_test;

    localparam int WAIT = 12;
    localparam int NACC = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        second_head = 1'b0;
    logic        done, present;
    logic        bus_req, bus_we;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ready = 1'b0;

    always #5 clk = ~clk;

    monitor_probe_seq #(.ADDR_W(4), .WAIT_CYCLES(WAIT)) uut (
        .clk (clk), .rst_n (rst_n), .start (start), .second_head (second_head),
        .done (done), .present (present), .bus_req (bus_req), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .bus_ready (bus_ready)
    );

    int errors = 0;
    int checks = 0;

    logic [31:0] m_out, m_tst, m_tdat;
    bit          mon;
    int          lat;
    int          idx, gap, wcnt, dones;
    bit          seen_req;
    bit          exp_we   [NACC];
    int          exp_addr [NACC];
    logic [31:0] exp_data [NACC];

    function automatic logic [31:0] tst_view(logic [31:0] s, bit m);
        logic [31:0] v = s;
        v[28] = m & s[12];
        return v;
    endfunction

    function automatic string tag_of(int i);
        case (i)
            0, 1, 11, 12: return "R2";
            2:            return "R3";
            3:            return "R4";
            4, 5:         return "R5";
            6:            return "R6";
            7, 8:         return "R7";
            default:      return "R8";
        endcase
    endfunction

    assign bus_rdata = (bus_addr == 4'd0) ? m_out :
                       (bus_addr == 4'd1) ? tst_view(m_tst, mon) :
                       (bus_addr == 4'd2) ? m_tdat : 32'h0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic put(input int i, input bit w, input int a, input logic [31:0] d);
        exp_we[i] = w; exp_addr[i] = a; exp_data[i] = d;
    endtask

    task automatic plan_run(input logic [31:0] o0, input logic [31:0] t0, input bit sh);
        logic [31:0] t0r, ocut, t1, t2, t2r;
        t0r  = tst_view(t0, mon);
        ocut = o0 & (sh ? 32'h0000_FEEE : 32'h0000_FFEE);
        t1   = t0r & ~(32'h1 << 16);
        t2   = tst_view(t1, mon) | (32'h1 << 12);
        t2r  = tst_view(t2, mon);
        put(0, 0, 0, 0);          put(1, 0, 1, 0);
        put(2, 1, 1, t1);         put(3, 1, 0, ocut);
        put(4, 0, 0, 0);          put(5, 1, 0, ocut | 32'h1);
        put(6, 1, 2, 32'h9405_0140);
        put(7, 0, 1, 0);          put(8, 1, 1, t2);
        put(9, 0, 1, 0);          put(10, 1, 1, t2r & ~(32'h1 << 12));
        put(11, 1, 0, o0);        put(12, 1, 1, t0r);
    endtask

    // behavioural register model, compared on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_ready) begin
                bus_ready = 1'b0;
                wcnt = 0; gap = 0; seen_req = 0;
            end
            if (done) begin
                check(idx == NACC, "R10", "done after all accesses", idx, NACC);
                check(present == mon, "R8", "present at done", present, mon);
                dones++;
            end else begin
                check(present == 1'b0, "R10", "present outside done", present, 0);
            end
            if (bus_req) begin
                if (!seen_req) begin
                    seen_req = 1;
                    if (idx == 4) check(gap == WAIT, "R5", "quiet gap after cut", gap, WAIT);
                    else if (idx == 9) check(gap == WAIT, "R7", "quiet gap after route", gap, WAIT);
                    else if (idx > 0 && idx < NACC) check(gap == 0, tag_of(idx), "gap", gap, 0);
                end
                if (wcnt >= lat) begin
                    if (idx >= NACC) begin
                        check(0, "R11", "extra access", {28'h0, bus_addr}, 0);
                    end else begin
                        check(bus_we == exp_we[idx] && int'(bus_addr) == exp_addr[idx],
                              tag_of(idx), $sformatf("access %0d kind/addr", idx),
                              {bus_we, 27'h0, bus_addr}, {exp_we[idx], 27'h0, 4'(exp_addr[idx])});
                        if (exp_we[idx])
                            check(bus_wdata == exp_data[idx], tag_of(idx),
                                  $sformatf("access %0d data", idx), bus_wdata, exp_data[idx]);
                        idx++;
                    end
                    if (bus_we) begin
                        case (bus_addr)
                            4'd0: m_out = bus_wdata;
                            4'd1: m_tst = bus_wdata;
                            4'd2: m_tdat = bus_wdata;
                            default: ;
                        endcase
                    end
                    bus_ready = 1'b1;
                end else begin
                    wcnt++;
                end
            end else begin
                gap++;
            end
        end
    end

    task automatic run(input logic [31:0] o0, input logic [31:0] t0, input bit m,
                       input bit sh, input int l, input bit mid_start);
        int d0;
        @(negedge clk);
        m_out = o0; m_tst = t0; m_tdat = 0; mon = m; lat = l;
        second_head = sh;
        idx = 0; gap = 0; wcnt = 0; seen_req = 0;
        plan_run(o0, t0, sh);
        d0 = dones;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int c = 0; c < 2000 && dones == d0; c++) @(negedge clk);
        check(dones == d0 + 1, "R10", "run finished (watchdog)", dones, d0 + 1);
        repeat (10) @(negedge clk);
        check(idx == NACC && !bus_req, "R11", "no accesses after done", idx, NACC);
        check(m_out == o0, "R2", "output-control restored", m_out, o0);
        check(m_tst == tst_view(t0, m), "R2", "test-control restored", m_tst, tst_view(t0, m));
    endtask

    initial begin
        mon = 0; lat = 0; idx = 0; gap = 0; wcnt = 0; dones = 0; seen_req = 0;
        m_out = 0; m_tst = 0; m_tdat = 0;
        plan_run(0, 0, 0);
        repeat (3) @(negedge clk);
        check(!bus_req && !done && !present, "R1", "reset outputs",
              {bus_req, done, present}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!bus_req && idx == 0, "R1", "idle without start", {31'h0, bus_req}, 0);
        run(32'hFFFF_FFFF, 32'h1001_0ABC, 1, 0, 0, 0);
        run(32'hFFFF_FFFF, 32'h0001_1000, 0, 1, 2, 0);
        run(32'h0000_0111, 32'h0000_0000, 0, 0, 1, 1);
        run(32'h1234_5678, 32'h0000_0000, 1, 1, 3, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule